// File: doc/BRIEF.md
# Serial Converter Port Emulator

This block is a synthesizable slave model of the digital serial side of an eight-channel, twelve-bit successive-approximation converter that runs on an externally supplied serial clock. It watches chip select, serial clock and serial data in. A conversion begins with a control byte: the first high bit seen while the port is waiting is taken as the start bit. The byte carries the channel number and the output polarity. After a fixed acquisition window the block pulses a strobe, then shifts out twelve result bits, most significant first, and fills any further clocks with zeros. The converted value is not sampled from an analog input. It is taken from a parallel sample bus that carries one twelve-bit word per channel.

The block runs on a fast system clock. The serial lines are passed through a short synchronizer and their edges are detected there. A four-state sequencer follows the serial edges: S_IDLE, S_CMD, S_ACQ and S_CONV.
- S_IDLE goes to S_CMD on a start bit.
- S_CMD goes to S_ACQ once the polarity bit has arrived.
- S_ACQ goes to S_CONV on the falling edge that ends acquisition. A new start bit received after the control byte sends S_ACQ back to S_CMD.
- S_CONV goes back to S_CMD on a new start bit (an abort). It goes to S_IDLE once the seventh result bit is about to be driven, after which a new byte may overlap the remaining readout.
- A high chip select forces S_IDLE.

A separate output shifter holds the result word and drives the two outputs. Each output has an enable that models the high-impedance state.

Top module: `sar_port_emu`

## Requirements
- R1: While cs_n is high, dout_oe and strobe_oe are 0 and any conversion in progress is abandoned with nothing left to shift. Once cs_n is low, both enables are 1 and dout and strobe drive 0 until a result appears.
- R2: With cs_n low and no conversion running, a 1 on din at a rising sclk edge is a start bit. Zeros before it are ignored, and the fall of cs_n by itself never produces a strobe or result.
- R3: The control byte is sent MSB first as: start bit, then channel number (three bits, MSB first, value = channel index 0..7), then a range bit, then a polarity bit, then two mode bits. The range and mode bits have no effect on the outputs.
- R4: Count the start-bit rising edge as serial clock 1. strobe rises on falling edge 12 and falls on falling edge 13, so it is high for exactly one serial clock.
- R5: Result bits D11 down to D0 are driven on dout on falling edges 13 through 24. dout is 0 on every later falling edge until the next result.
- R6: The result is the sample word of the selected channel as it stands at falling edge 12. Later changes to the sample bus do not alter it.
- R7: Polarity bit 0 gives the sample word unchanged (straight binary). Polarity bit 1 gives the word with its MSB inverted (two's complement).
- R8: A 1 on din at rising edge 9 through 18 aborts the running conversion. No further bits of it appear, dout is 0 from the next falling edge, and that bit is the start bit of a new control byte.
- R9: A 1 on din at rising edge 19 or later starts a new conversion while the old D5..D0 still shift out unchanged, allowing one conversion every 18 serial clocks.
- R10: din values at rising edges 2 through 8 are control bits and are never taken as a start bit, even when all are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial control data, sampled on sclk rising edges |
| samples | input | CHANNELS*RES_BITS (96) | Per-channel sample words, channel c at bits c*12 +: 12 |
| dout | output | 1 | Serial result data, changes after sclk falling edges |
| dout_oe | output | 1 | Drive enable for dout (0 = high impedance) |
| strobe | output | 1 | End-of-acquisition pulse |
| strobe_oe | output | 1 | Drive enable for strobe (0 = high impedance) |

## Verification
The bench builds the block with its default parameters: eight channels, twelve-bit results, a six-clock acquisition, a two-stage synchronizer and the guard at bit D6. Together with a serial half period of six system clocks, this covers every boundary of the abort window (rising edges 9, 13 and 18) and the earliest overlapping start at edge 19. It also covers the full eight-way channel decode, with the sample bus changing around the capture edge. Because the result width is twelve and the guard bit is six, every sample word also exercises the split between bits that an abort can cut short and bits that always finish.

// File: rtl/spe_pkg.sv
package spe_pkg;

    // sequencer states
    typedef enum logic [1:0] {
        S_IDLE,  // waiting for a start bit
        S_CMD,   // receiving channel, range and polarity bits
        S_ACQ,   // acquisition window, tail of control byte
        S_CONV   // result shifting, abort still possible
    } seq_state_e;

endpackage

// File: rtl/spe_insync.sv
module spe_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_act,
    output logic rise,
    output logic fall,
    output logic din_s
);

    localparam int PW = STAGES * 3;
    localparam logic [PW-1:0] RST_V = {STAGES{3'b100}};

    logic [PW-1:0] pipe_q;
    logic [2:0]    tail;
    logic          sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q      <= RST_V;
            sclk_prev_q <= 1'b0;
        end else begin
            pipe_q      <= {pipe_q[PW-4:0], cs_n, sclk, din};
            sclk_prev_q <= tail[1];
        end
    end

    assign tail   = pipe_q[PW-1 -: 3];
    assign cs_act = ~tail[2];
    assign din_s  = tail[0];
    assign rise   = cs_act & tail[1] & ~sclk_prev_q;
    assign fall   = cs_act & ~tail[1] & sclk_prev_q;

endmodule

// File: rtl/spe_seq.sv
module spe_seq
    import spe_pkg::*;
#(
    parameter int SEL_BITS  = 3,
    parameter int RES_BITS  = 12,
    parameter int ACQ_CLKS  = 6,
    parameter int GUARD_BIT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_act,
    input  logic                rise,
    input  logic                fall,
    input  logic                din,
    output logic                load_o,
    output logic                kill_o,
    output logic [SEL_BITS-1:0] chan_o,
    output logic                bip_o
);

    // edge counts, start bit rising edge = 1
    localparam int ACQ_AT     = SEL_BITS + 3;               // polarity bit received
    localparam int CTRL_BITS  = ACQ_AT + 2;                 // full control byte
    localparam int STB_CNT    = ACQ_AT + ACQ_CLKS;          // end of acquisition
    localparam int LAST_ABORT = STB_CNT + RES_BITS - GUARD_BIT;
    localparam int CW         = $clog2(LAST_ABORT + 1);

    seq_state_e          state_q, state_d;
    logic [CW-1:0]       cnt_q, cnt_d;
    logic [SEL_BITS-1:0] sel_q, sel_d;
    logic                bip_q, bip_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
            bip_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_d;
            bip_q   <= bip_d;
        end
    end

    // next state and pulses
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sel_d   = sel_q;
        bip_d   = bip_q;
        load_o  = 1'b0;
        kill_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (rise && din) begin          // R2 start bit
                    state_d = S_CMD;
                    cnt_d   = CW'(1);
                end
            end
            S_CMD: begin
                if (rise) begin                 // R10 bits are data here
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q <= CW'(SEL_BITS))
                        sel_d = {sel_q[SEL_BITS-2:0], din};
                    if (cnt_q == CW'(ACQ_AT - 1)) begin
                        bip_d   = din;
                        state_d = S_ACQ;
                    end
                end
            end
            S_ACQ: begin
                if (rise) begin
                    if (cnt_q >= CW'(CTRL_BITS) && din) begin   // R8
                        kill_o  = 1'b1;
                        state_d = S_CMD;
                        cnt_d   = CW'(1);
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end else if (fall && cnt_q == CW'(STB_CNT)) begin  // R4
                    load_o  = 1'b1;
                    state_d = S_CONV;
                end
            end
            S_CONV: begin
                if (rise) begin
                    if (din) begin                              // R8
                        kill_o  = 1'b1;
                        state_d = S_CMD;
                        cnt_d   = CW'(1);
                    end else if (cnt_q == CW'(LAST_ABORT - 1)) begin  // R9
                        state_d = S_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (!cs_act) begin                                      // R1
            state_d = S_IDLE;
            cnt_d   = '0;
            load_o  = 1'b0;
            kill_o  = 1'b0;
        end
    end

    assign chan_o = sel_q;
    assign bip_o  = bip_q;

    a_r1_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state_q == S_IDLE && cnt_q == '0));

    a_r8_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |=> (state_q == S_CMD && cnt_q == CW'(1)));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !(rise && din)) |=> (state_q == S_IDLE));

endmodule

// File: rtl/spe_outsh.sv
module spe_outsh #(
    parameter int CHANNELS = 8,
    parameter int RES_BITS = 12,
    parameter int SEL_BITS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_act,
    input  logic                         fall,
    input  logic                         load,
    input  logic                         kill,
    input  logic [SEL_BITS-1:0]          chan,
    input  logic                         bip,
    input  logic [CHANNELS*RES_BITS-1:0] samples,
    output logic                         dout,
    output logic                         dout_oe,
    output logic                         strobe,
    output logic                         strobe_oe
);

    logic [RES_BITS-1:0] picked, code;
    logic [RES_BITS-1:0] sh_q;
    logic                stb_q, dout_q, oe_q;

    // R3 channel pick, R7 polarity format
    always_comb begin
        picked = samples[int'(chan)*RES_BITS +: RES_BITS];
        code   = bip ? {~picked[RES_BITS-1], picked[RES_BITS-2:0]} : picked;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            stb_q  <= 1'b0;
            dout_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (!cs_act) begin
            sh_q   <= '0;
            stb_q  <= 1'b0;
            dout_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= 1'b1;
            if (kill)
                sh_q <= '0;
            if (fall) begin
                if (load) begin                 // R6 capture point
                    sh_q   <= code;
                    stb_q  <= 1'b1;
                    dout_q <= 1'b0;
                end else begin                  // R5 shift with zero fill
                    stb_q  <= 1'b0;
                    dout_q <= sh_q[RES_BITS-1];
                    sh_q   <= {sh_q[RES_BITS-2:0], 1'b0};
                end
            end
        end
    end

    assign dout      = dout_q;
    assign dout_oe   = oe_q;
    assign strobe    = stb_q;
    assign strobe_oe = oe_q;

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && fall && stb_q) |=> !stb_q);

    a_r8_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && kill) |=> (sh_q == '0));

    a_r1_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!oe_q && !stb_q && !dout_q));

    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && fall && !load && sh_q == '0) |=> !dout_q);

endmodule

// File: rtl/sar_port_emu.sv
module sar_port_emu #(
    parameter int CHANNELS    = 8,
    parameter int RES_BITS    = 12,
    parameter int ACQ_CLKS    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int GUARD_BIT   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sclk,
    input  logic                         din,
    input  logic [CHANNELS*RES_BITS-1:0] samples,
    output logic                         dout,
    output logic                         dout_oe,
    output logic                         strobe,
    output logic                         strobe_oe
);

    localparam int SEL_BITS = $clog2(CHANNELS);

    logic                cs_act, rise, fall, din_s;
    logic                load, kill, bip;
    logic [SEL_BITS-1:0] chan;

    spe_insync #(
        .STAGES (SYNC_STAGES)
    ) u_insync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .din    (din),
        .cs_act (cs_act),
        .rise   (rise),
        .fall   (fall),
        .din_s  (din_s)
    );

    spe_seq #(
        .SEL_BITS  (SEL_BITS),
        .RES_BITS  (RES_BITS),
        .ACQ_CLKS  (ACQ_CLKS),
        .GUARD_BIT (GUARD_BIT)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_act (cs_act),
        .rise   (rise),
        .fall   (fall),
        .din    (din_s),
        .load_o (load),
        .kill_o (kill),
        .chan_o (chan),
        .bip_o  (bip)
    );

    spe_outsh #(
        .CHANNELS (CHANNELS),
        .RES_BITS (RES_BITS),
        .SEL_BITS (SEL_BITS)
    ) u_outsh (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .fall      (fall),
        .load      (load),
        .kill      (kill),
        .chan      (chan),
        .bip       (bip),
        .samples   (samples),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .strobe    (strobe),
        .strobe_oe (strobe_oe)
    );

endmodule

// File: tb/test_sar_port_emu.sv
module test_sar_port_emu;

    localparam int CH = 8;
    localparam int RB = 12;
    localparam int H  = 6;     // system clocks per sclk half period
    localparam int N  = 160;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [CH*RB-1:0] samples = '0;
    logic dout, dout_oe, strobe, strobe_oe;

    always #2 clk = ~clk;   // 250 MHz

    sar_port_emu i_sar_port_emu (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .samples(samples), .dout(dout), .dout_oe(dout_oe),
        .strobe(strobe), .strobe_oe(strobe_oe)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    bit    exp_d [N];
    bit    exp_s [N];
    string exp_tag [N];
    bit    din_seq [N];
    int    c_start [4], c_abort [4], c_chan [4];
    bit    c_bip [4], c_rng [4];
    bit [1:0] c_mode [4];
    int    ncv, len, cur_kind;

    function automatic logic [RB-1:0] expect_code(logic [RB-1:0] raw, bit bip);
        return bip ? {~raw[RB-1], raw[RB-2:0]} : raw;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // one serial clock; outputs sampled just before the rising edge
    task automatic serial_tick(input bit d, input logic [CH*RB-1:0] ns,
                               output logic od, output logic odoe,
                               output logic os, output logic osoe);
        din = d;
        repeat (H) @(negedge clk);
        od = dout; odoe = dout_oe; os = strobe; osoe = strobe_oe;
        sclk = 1'b1;
        samples = ns;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic build(input int kind, input int gap);
        int prev;
        cur_kind = kind;
        for (int t = 0; t < N; t++) begin
            exp_d[t] = 0; exp_s[t] = 0; exp_tag[t] = "R2"; din_seq[t] = 0;
        end
        ncv = (kind == 0 || kind == 5) ? 1 : (kind == 4 ? 2 : 2 + $urandom_range(0, 2));
        prev = $urandom_range(0, 5);
        c_start[0] = prev;
        for (int i = 1; i < ncv; i++) begin
            int g;
            if (kind == 4)      g = gap;
            else if (kind == 1) g = 18 + $urandom_range(0, 3);
            else if (kind == 2) g = 8 + $urandom_range(0, 9);
            else                g = $urandom_range(0, 1) ? 18 + $urandom_range(0, 3) : 8 + $urandom_range(0, 9);
            c_start[i] = c_start[i-1] + g;
            c_abort[i-1] = (g <= 17) ? g + 1 : 0;
        end
        c_abort[ncv-1] = 0;
        len = c_start[ncv-1] + 28;
        for (int i = 0; i < ncv; i++) begin
            int s;
            s = c_start[i];
            c_chan[i] = (kind == 5) ? 7 : $urandom_range(0, CH-1);
            c_rng[i]  = (kind == 5) ? 1 : 1'($urandom_range(0, 1));
            c_bip[i]  = (kind == 5) ? 1 : 1'($urandom_range(0, 1));
            c_mode[i] = (kind == 5) ? 2'b11 : 2'($urandom_range(0, 3));
            // R3 byte order: start, chan[2:0], range, polarity, mode[1:0]
            din_seq[s]   = 1;
            din_seq[s+1] = c_chan[i][2];
            din_seq[s+2] = c_chan[i][1];
            din_seq[s+3] = c_chan[i][0];
            din_seq[s+4] = c_rng[i];
            din_seq[s+5] = c_bip[i];
            din_seq[s+6] = c_mode[i][1];
            din_seq[s+7] = c_mode[i][0];
            for (int t = s + 25; t < s + 28; t++) exp_tag[t] = "R5";
        end
        for (int i = 0; i < ncv; i++)
            if (c_abort[i] == 0 || c_abort[i] >= 13) begin
                exp_s[c_start[i] + 12] = 1;
                exp_tag[c_start[i] + 12] = "R4";
            end
    endtask

    task automatic run_stream(input int cut);
        logic od, odoe, os, osoe;
        logic [CH*RB-1:0] ns;
        int stop;
        stop = (cut > 0) ? cut : len;
        cs_n = 1'b0;
        for (int t = 0; t < stop; t++) begin
            ns = samples;
            if (cur_kind == 0 || $urandom_range(0, 1) == 1)
                for (int c = 0; c < CH; c++) ns[c*RB +: RB] = RB'($urandom);
            for (int i = 0; i < ncv; i++) begin
                int s;
                s = c_start[i];
                if (s + 11 == t && (c_abort[i] == 0 || c_abort[i] >= 13)) begin
                    logic [RB-1:0] w;
                    w = expect_code(ns[c_chan[i]*RB +: RB], c_bip[i]);
                    for (int j = 0; j < RB; j++) begin
                        if (c_abort[i] == 0 || 13 + j < c_abort[i]) begin
                            exp_d[s+13+j] = w[RB-1-j];
                            if (cur_kind == 5)                  exp_tag[s+13+j] = "R10";
                            else if (i > 0 && c_abort[i-1] == 0) exp_tag[s+13+j] = "R9";
                            else if (c_bip[i])                  exp_tag[s+13+j] = "R7";
                            else if (cur_kind == 0)             exp_tag[s+13+j] = "R6";
                            else                                exp_tag[s+13+j] = "R3";
                        end else begin
                            exp_d[s+13+j] = 0;
                            exp_tag[s+13+j] = "R8";
                        end
                    end
                end
            end
            serial_tick(din_seq[t], ns, od, odoe, os, osoe);
            check(exp_tag[t], "dout", od, exp_d[t]);
            check(exp_s[t] ? "R4" : exp_tag[t], "strobe", os, exp_s[t]);
            check("R1", "dout_oe", odoe, 1'b1);
            check("R1", "strobe_oe", osoe, 1'b1);
        end
    endtask

    task automatic cs_gap(input int n);
        logic od, odoe, os, osoe;
        cs_n = 1'b1;
        for (int t = 0; t < n; t++) begin
            serial_tick(1'($urandom_range(0, 1)), samples, od, odoe, os, osoe);
            check("R1", "dout_oe high-z", odoe, 1'b0);
            check("R1", "strobe_oe high-z", osoe, 1'b0);
        end
    endtask

    task automatic run_idle(input int n, input string tag);
        logic od, odoe, os, osoe;
        cs_n = 1'b0;
        for (int t = 0; t < n; t++) begin
            serial_tick(1'b0, samples, od, odoe, os, osoe);
            check(tag, "idle dout", od, 1'b0);
            check(tag, "idle strobe", os, 1'b0);
            check("R1", "idle dout_oe", odoe, 1'b1);
            check("R1", "idle strobe_oe", osoe, 1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state: outputs released
        check("R1", "reset dout_oe", dout_oe, 1'b0);
        check("R1", "reset strobe_oe", strobe_oe, 1'b0);
        check("R1", "reset strobe", strobe, 1'b0);

        // R2: chip select falling alone starts nothing
        run_idle(30, "R2");
        cs_gap(2);

        // R10: all-ones control byte
        build(5, 0); run_stream(0); cs_gap(2);

        // R8 abort boundaries at rising edges 9, 13 and 18; R9 at 19 and 20
        build(4, 8);  run_stream(0); cs_gap(2);
        build(4, 12); run_stream(0); cs_gap(2);
        build(4, 17); run_stream(0); cs_gap(2);
        build(4, 18); run_stream(0); cs_gap(2);
        build(4, 19); run_stream(0); cs_gap(2);

        // R1: chip select high mid-readout abandons the conversion
        build(0, 0);
        run_stream(c_start[0] + 16);
        cs_gap(3);
        run_idle(30, "R1");
        cs_gap(2);

        // constrained random mix
        for (int k = 0; k < 24; k++) begin
            build($urandom_range(0, 3), 0);
            run_stream(0);
            cs_gap(2);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule